// File: doc/BRIEF.md
# Byte-Sliced Iterative Multiplier

This block multiplies two 32-bit operands over several clock cycles. While it works, it holds a stall line high so that the surrounding pipeline freezes. A one-cycle start pulse loads the operands together with a mode bit that selects signed or unsigned arithmetic. In signed mode each operand is first turned into its magnitude, and the block records which operands were negative. On each working cycle a 32x8 gated-adder array multiplies the full multiplicand by one 8-bit slice of the multiplier. The 40-bit partial product is shifted into place and added to a 64-bit accumulator. Four slices finish a multiply. If exactly one signed operand was negative, the total is negated before it goes into the result register.

A two-state controller (idle = 0, running = 1) drives the stall output straight from its next-state logic. The stall therefore rises in the same cycle the start pulse is seen, without waiting for a register. It falls in the cycle the datapath reports completion. The product is presented as separate low and high 32-bit words. The block holds these words once the stall drops.

Top module: `bslice_mul`

## Requirements
- R1: A synchronous active-high reset forces the idle state and clears the slice counter, the accumulator and the result. After reset, busy_o is 0 and both product words are 0.
- R2: busy_o is 1 during a cycle in which start_i is 1 and the block is idle. It does not wait for a clock edge.
- R3: Take the clock edge at which the start is accepted. busy_o stays 1 for the four cycles after that edge. It is 0 in the fifth cycle, and the block is idle from the sixth.
- R4: A start_i pulse that arrives while the block is running has no effect, and this includes the cycle in which busy_o falls. It neither reloads the operands nor changes the cycle count or the result.
- R5: With signed_i = 0 at the start, {prod_hi_o, prod_lo_o} equals the 64-bit unsigned product of op_a_i and op_b_i.
- R6: With signed_i = 1 at the start, {prod_hi_o, prod_lo_o} equals the 64-bit two's-complement product. This includes operands equal to the most negative value, 0x80000000.
- R7: The slice counter runs 0 to 3. On count k the block uses multiplier bits [8k+7:8k] and adds their partial product shifted left by 8k bits. A multiplier with one non-zero byte in any position therefore yields that byte's weighted product.
- R8: prod_lo_o carries product bits [31:0] and prod_hi_o carries bits [63:32]. Both hold their value from the cycle busy_o falls until the next accepted start, whatever the operand inputs do.
- R9: A start presented in the cycle right after the release cycle is accepted. Back-to-back multiplies then run without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; acted on only when idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier (consumed one byte per cycle) |
| busy_o | output | 1 | Stall request, equal to the next controller state |
| prod_lo_o | output | 32 | Product bits 31:0 |
| prod_hi_o | output | 32 | Product bits 63:32 |

## Verification
The bench drives multiplier values that have a single non-zero byte in each position. A design that picked the wrong slice or the wrong shift would put that byte's weight at the wrong place in the product. Signed tests use 0x80000000, minus one and mixed signs. A wrong magnitude capture or a missing final negation would show up there as a wrong or sign-flipped high word. The bench also sends start pulses during the running cycles and during the release cycle, then changes the operands while idle. A design that reloaded operands, counted wrongly or let the result drift would break the five-cycle busy pattern or the held product. Reset is asserted in the middle of a multiply, which would expose a counter or result that is not cleared.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    localparam int DEF_WIDTH = 32;
    localparam int DEF_SLICE = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bsm_state_e;

    typedef struct packed {
        logic is_signed;
        logic neg_a;
        logic neg_b;
    } bsm_sign_t;

    function automatic logic flip_result(input bsm_sign_t s);
        return s.is_signed & (s.neg_a ^ s.neg_b);
    endfunction

endpackage

// File: rtl/bsm_pp_array.sv
module bsm_pp_array #(
    parameter int WIDTH = bsm_pkg::DEF_WIDTH,
    parameter int SLICE = bsm_pkg::DEF_SLICE
) (
    input  logic [WIDTH-1:0]       mcand_i,
    input  logic [SLICE-1:0]       slice_i,
    output logic [WIDTH+SLICE-1:0] pp_o
);
    localparam int PP_W = WIDTH + SLICE;

    logic [PP_W-1:0] rows [SLICE];

    for (genvar g = 0; g < SLICE; g++) begin : g_row
        assign rows[g] = slice_i[g] ? (PP_W'(mcand_i) << g) : '0;
    end

    always_comb begin
        pp_o = '0;
        for (int i = 0; i < SLICE; i++) begin
            pp_o = pp_o + rows[i];
        end
    end
endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                done_i,
    output bsm_pkg::bsm_state_e state_o,
    output logic                busy_o,
    output logic                load_o,
    output logic                step_o
);
    import bsm_pkg::*;

    bsm_state_e st_q, st_nxt;

    always_comb begin
        st_nxt = st_q;
        case (st_q)
            ST_IDLE: if (start_i) st_nxt = ST_RUN;
            ST_RUN:  if (done_i)  st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nxt;
    end

    assign busy_o  = (st_nxt == ST_RUN);
    assign load_o  = (st_q == ST_IDLE) && start_i;
    assign step_o  = (st_q == ST_RUN) && !done_i;
    assign state_o = st_q;
endmodule

// File: rtl/bsm_datapath.sv
module bsm_datapath #(
    parameter int WIDTH = bsm_pkg::DEF_WIDTH,
    parameter int SLICE = bsm_pkg::DEF_SLICE,
    localparam int NSLICE = WIDTH / SLICE,
    localparam int IDX_W  = $clog2(NSLICE),
    localparam int CNT_W  = $clog2(NSLICE + 1),
    localparam int PP_W   = WIDTH + SLICE,
    localparam int PR_W   = 2 * WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [PR_W-1:0]  prod_o
);
    import bsm_pkg::*;

    logic [WIDTH-1:0] mag_a_q, mag_b_q, mag_a_in, mag_b_in;
    bsm_sign_t        sign_q, sign_in;
    logic [CNT_W-1:0] cnt_q;
    logic [PR_W-1:0]  acc_q, acc_nxt, res_q;
    logic [IDX_W-1:0] idx;
    logic [SLICE-1:0] cur_slice;
    logic [PP_W-1:0]  pp;
    logic             last;

    always_comb begin
        sign_in.is_signed = signed_i;
        sign_in.neg_a     = signed_i & op_a_i[WIDTH-1];
        sign_in.neg_b     = signed_i & op_b_i[WIDTH-1];
        mag_a_in = sign_in.neg_a ? (WIDTH'(0) - op_a_i) : op_a_i;
        mag_b_in = sign_in.neg_b ? (WIDTH'(0) - op_b_i) : op_b_i;
    end

    assign idx       = cnt_q[IDX_W-1:0];
    assign cur_slice = mag_b_q[int'(idx)*SLICE +: SLICE];

    bsm_pp_array #(.WIDTH(WIDTH), .SLICE(SLICE)) u_pp (
        .mcand_i (mag_a_q),
        .slice_i (cur_slice),
        .pp_o    (pp)
    );

    assign acc_nxt = acc_q + (PR_W'(pp) << (SLICE * int'(idx)));
    assign last    = (cnt_q == CNT_W'(NSLICE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_a_q <= '0;
            mag_b_q <= '0;
            sign_q  <= '0;
            cnt_q   <= '0;
            acc_q   <= '0;
            res_q   <= '0;
        end else if (load_i) begin
            mag_a_q <= mag_a_in;
            mag_b_q <= mag_b_in;
            sign_q  <= sign_in;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else if (step_i) begin
            acc_q <= acc_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
                res_q <= flip_result(sign_q) ? (PR_W'(0) - acc_nxt) : acc_nxt;
            end
        end
    end

    assign done_o = (cnt_q == CNT_W'(NSLICE));
    assign cnt_o  = cnt_q;
    assign prod_o = res_q;
endmodule

// File: rtl/bslice_mul.sv
module bslice_mul #(
    parameter int WIDTH = bsm_pkg::DEF_WIDTH,
    parameter int SLICE = bsm_pkg::DEF_SLICE,
    localparam int NSLICE = WIDTH / SLICE,
    localparam int CNT_W  = $clog2(NSLICE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] prod_lo_o,
    output logic [WIDTH-1:0] prod_hi_o
);
    import bsm_pkg::*;

    bsm_state_e         state_w;
    logic               done_w, load_w, step_w;
    logic [CNT_W-1:0]   cnt_w;
    logic [2*WIDTH-1:0] prod_w;

    bsm_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .done_i  (done_w),
        .state_o (state_w),
        .busy_o  (busy_o),
        .load_o  (load_w),
        .step_o  (step_w)
    );

    bsm_datapath #(.WIDTH(WIDTH), .SLICE(SLICE)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_w),
        .step_i   (step_w),
        .signed_i (signed_i),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .done_o   (done_w),
        .cnt_o    (cnt_w),
        .prod_o   (prod_w)
    );

    assign prod_lo_o = prod_w[WIDTH-1:0];
    assign prod_hi_o = prod_w[2*WIDTH-1:WIDTH];
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
    parameter int NSLICE = 4,
    parameter int CNT_W  = 3,
    parameter int PR_W   = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             state,
    input logic             done,
    input logic [CNT_W-1:0] cnt,
    input logic [PR_W-1:0]  prod
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!state && cnt == '0 && prod == '0)); // R1

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        (!state && start) |-> busy); // R2

    AST_BUSY_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        (state && !done) |-> busy); // R3

    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state && done) |=> !state); // R3

    AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (rst)
        (state && done) |-> !busy); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state && start && !done) |=> (state && cnt == CNT_W'($past(cnt) + 1'b1))); // R4

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(NSLICE)); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !state |=> $stable(prod)); // R8
endmodule

bind bslice_mul bsm_checker #(
    .NSLICE (NSLICE),
    .CNT_W  (CNT_W),
    .PR_W   (2*WIDTH)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .busy  (busy_o),
    .state (state_w),
    .done  (done_w),
    .cnt   (cnt_w),
    .prod  (prod_w)
);

// File: tb/bslice_mul_test.sv
module bslice_mul_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic        busy_o;
    logic [31:0] prod_lo_o, prod_hi_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bslice_mul uut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .signed_i  (signed_i),
        .op_a_i    (op_a_i),
        .op_b_i    (op_b_i),
        .busy_o    (busy_o),
        .prod_lo_o (prod_lo_o),
        .prod_hi_o (prod_hi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input bit sg);
        logic [63:0] xa, xb;
        xa = sg ? {{32{a[31]}}, a} : {32'b0, a};
        xb = sg ? {{32{b[31]}}, b} : {32'b0, b};
        return xa * xb;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] prod();
        return {prod_hi_o, prod_lo_o};
    endfunction

    // One multiply; inputs change at negedges, outputs sampled there.
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input bit sg,
                         input bit poke, input string tag);
        logic [63:0] exp;
        exp = ref_mul(a, b, sg);
        @(negedge clk);
        op_a_i = a; op_b_i = b; signed_i = sg; start_i = 1'b1;
        #1 check(busy_o === 1'b1, "R2 busy with start", 64'(busy_o), 64'd1);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (poke && i == 2) begin
                start_i = 1'b1; op_a_i = ~a; op_b_i = b + 32'd3; signed_i = ~sg;
            end
            #1 check(busy_o === 1'b1, "R3 busy during run", 64'(busy_o), 64'd1);
        end
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            start_i = 1'b1; op_a_i = a + 32'd7; op_b_i = ~b;
        end
        #1 check(busy_o === 1'b0, "R3 busy drops in fifth cycle", 64'(busy_o), 64'd0);
        check(prod() === exp, tag, prod(), exp);
        if (poke) begin
            @(negedge clk);
            start_i = 1'b0;
            #1 check(busy_o === 1'b0, "R4 start in release cycle ignored", 64'(busy_o), 64'd0);
            check(prod() === exp, "R4 result untouched by ignored start", prod(), exp);
        end
    endtask

    task automatic idle_hold(input int n);
        logic [63:0] held;
        held = prod();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            op_a_i = $urandom; op_b_i = $urandom; signed_i = $urandom;
        end
        #1 check(prod() === held, "R8 product held while idle", prod(), held);
        check(busy_o === 1'b0, "R8 busy low while idle", 64'(busy_o), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check(busy_o === 1'b0, "R1 busy after reset", 64'(busy_o), 64'd0);
        check(prod() === 64'd0, "R1 product after reset", prod(), 64'd0);

        // R5 unsigned directed
        do_op(32'd0, 32'd12345, 1'b0, 1'b0, "R5 zero operand");
        do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5 max unsigned");
        do_op(32'd3, 32'd5, 1'b0, 1'b0, "R5 small unsigned");
        // R9 back to back: next start right after the release cycle
        @(negedge clk); start_i = 1'b0;
        do_op(32'd7, 32'd9, 1'b0, 1'b0, "R9 back-to-back first");
        do_op(32'd11, 32'd13, 1'b0, 1'b0, "R9 back-to-back second");

        // R7 one non-zero byte in each slice position
        for (int k = 0; k < 4; k++) begin
            do_op(32'hDEAD_BEEF, 32'hA5 << (8*k), 1'b0, 1'b0, "R7 single byte slice");
            do_op(32'h8000_0001, 32'hFF << (8*k), 1'b1, 1'b0, "R7 signed byte slice");
        end

        // R6 signed directed
        do_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R6 min times min");
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R6 min times minus one");
        do_op(32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0, "R6 minus one times one");
        do_op(32'd100, 32'hFFFF_FF9C, 1'b1, 1'b0, "R6 positive times negative");
        do_op(32'hFFFF_FFF9, 32'hFFFF_FFFD, 1'b1, 1'b0, "R6 negative times negative");

        // R4 starts while running and in release cycle
        do_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1, "R4 unsigned with pokes");
        do_op(32'hF000_0001, 32'h0000_1234, 1'b1, 1'b1, "R4 signed with pokes");
        idle_hold(3);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            logic [31:0] a, b;
            bit sg;
            a = $urandom; b = $urandom; sg = $urandom;
            do_op(a, b, sg, (n % 7) == 0, sg ? "R6 random signed" : "R5 random unsigned");
            if (n % 5 == 0) idle_hold(2);
        end

        // R1 reset in the middle of a multiply
        @(negedge clk);
        op_a_i = 32'd99; op_b_i = 32'd77; signed_i = 1'b0; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check(busy_o === 1'b0, "R1 busy cleared by mid-run reset", 64'(busy_o), 64'd0);
        check(prod() === 64'd0, "R1 result cleared by mid-run reset", prod(), 64'd0);
        do_op(32'd99, 32'd77, 1'b0, 1'b0, "R1 multiply after reset");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule